// File: doc/BRIEF.md
# Multi-Match PWM and Quadrature Generator

This block produces up to four pulse-width-modulated outputs from a single shared up-counter. The counter starts at zero, advances on every cycle in which the tick enable is high, and returns to zero after it reaches a programmable limit. Each output owns two compare values. When the counter equals the first value, the output is driven high. When it equals the second value, the output is driven low.

Every output has its own rising and falling compare points on the same timebase. Giving all outputs a rising point of zero produces edge-aligned PWM with a shared phase. Rising points that differ shift each output's phase. Two outputs at 50% duty with rising points a quarter period apart form a quadrature pair.

Software writes go into a staging copy of every register. The running copy is replaced only at the wrap, so a period never mixes old and new settings.

Top module: `pwm_match_gen`

## Requirements
- R1: While reset is high, and after its release until the first tick, every PWM output and the wrap pulse are low. The counter restarts from zero.
- R2: With tick held high and a limit L in force, the wrap pulse appears exactly once every L+1 cycles.
- R3: The wrap pulse is one cycle long and is high only in the cycle after a tick at which the counter equalled the limit. That same cycle is the one in which the counter reads zero.
- R4: In a cycle where tick is low, the counter, all PWM outputs and the wrap pulse keep their values. Counting resumes from the same point once tick returns.
- R5: Address 2n holds the rising compare value of output n. A tick at which the counter equals it drives output n high in the next cycle.
- R6: Address 2n+1 holds the falling compare value of output n. A tick at which the counter equals it drives output n low in the next cycle. A rising value of 0 and a falling value of D give D high cycles per period.
- R7: If the rising and falling compare values of an output match the counter on the same tick, the output goes low. After reset all compare values are zero, so every output stays low.
- R8: Writes change only the staging copy. The limit and all compare values in use change together, at the tick where the counter wraps, and the period in progress finishes with the old settings.
- R9: A rising value above zero delays the rising edge. A rising value larger than the falling value gives a pulse that wraps across the period boundary.
- R10: Two outputs at 50% duty whose rising values differ by a quarter of the period are in quadrature, one lagging the other by that quarter.
- R11: Address 2·NUM_OUT holds the limit. Writes to any higher address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Count enable; one count step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | $clog2(2·NUM_OUT+1) | Write address: compare registers, then limit |
| wr_data_i | input | CNT_W | Write data |
| pwm_o | output | NUM_OUT | PWM / quadrature outputs |
| wrap_o | output | 1 | One-cycle pulse marking the counter's return to zero |

## Verification
The bench keeps the 16-bit counter and the four outputs. It overrides the reset limit to 7, so the default settings take effect after eight ticks rather than 65,536. Short limits of 7 and 9 bring several complete periods within a few hundred cycles. These include the staged-write handover, a tick freeze in the middle of a pulse, wrap-around pulses and a quadrature set. Only the limit register, compare addresses 0 to 7 and the unused addresses 9 to 15 of the 4-bit address space are exercised.

// File: rtl/pmg_pkg.sv
package pmg_pkg;

    // Action an output channel takes on a tick.
    typedef enum logic [1:0] {
        PA_HOLD = 2'd0,
        PA_SET  = 2'd1,
        PA_CLR  = 2'd2
    } pin_act_e;

    // Compare results for one output on one tick.
    typedef struct packed {
        logic rise_hit;
        logic fall_hit;
    } pair_hit_t;

    // The falling compare outranks the rising one.
    function automatic pin_act_e pick_act(input pair_hit_t h);
        if (h.fall_hit) return PA_CLR;
        if (h.rise_hit) return PA_SET;
        return PA_HOLD;
    endfunction

    function automatic int unsigned addr_bits(input int unsigned n_out);
        return $clog2(2 * n_out + 1);
    endfunction

endpackage

// File: rtl/pmg_regbank.sv
module pmg_regbank #(
    parameter int unsigned      CNT_W     = 16,
    parameter int unsigned      NUM_OUT   = 4,
    parameter logic [CNT_W-1:0] LIMIT_RST = '1,
    localparam int unsigned     NUM_CMP   = 2 * NUM_OUT,
    localparam int unsigned     ADDR_W    = pmg_pkg::addr_bits(NUM_OUT)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en_i,
    input  logic [ADDR_W-1:0]               wr_addr_i,
    input  logic [CNT_W-1:0]                wr_data_i,
    input  logic                            load_i,
    output logic [CNT_W-1:0]                lim_o,
    output logic [NUM_OUT-1:0][CNT_W-1:0]   rise_o,
    output logic [NUM_OUT-1:0][CNT_W-1:0]   fall_o
);
    localparam logic [ADDR_W-1:0] LIM_ADDR = ADDR_W'(NUM_CMP);

    logic [CNT_W-1:0]               stg_lim, run_lim;
    logic [NUM_CMP-1:0][CNT_W-1:0]  stg_cmp, run_cmp;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_lim <= LIMIT_RST;
            run_lim <= LIMIT_RST;
        end else begin
            if (wr_en_i && wr_addr_i == LIM_ADDR) stg_lim <= wr_data_i;
            if (load_i) run_lim <= stg_lim;
        end
    end

    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst) begin
                stg_cmp[i] <= '0;
                run_cmp[i] <= '0;
            end else begin
                if (wr_en_i && wr_addr_i == ADDR_W'(i)) stg_cmp[i] <= wr_data_i;
                if (load_i) run_cmp[i] <= stg_cmp[i];
            end
        end
    end

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_pair
        assign rise_o[n] = run_cmp[2*n];
        assign fall_o[n] = run_cmp[2*n+1];
    end

    assign lim_o = run_lim;

    // R8: the running copy only moves at a wrap
    a_r8_run_held: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ($stable(run_lim) && $stable(run_cmp)));

    // R11: out-of-range addresses leave the staging copy untouched
    a_r11_bad_addr_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i > LIM_ADDR) |=> ($stable(stg_lim) && $stable(stg_cmp)));

endmodule

// File: rtl/pmg_counter.sv
module pmg_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             load_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap_q;
    logic             at_lim;

    assign at_lim = (cnt_q == lim_i);
    assign load_o = tick_i && at_lim;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= load_o;
            if (tick_i) cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = wrap_q;

    // R2: the counter never passes the limit in force
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= lim_i);

    // R3: a wrap pulse follows a tick and coincides with a zero count
    a_r3_wrap_after_tick: assert property (@(posedge clk) disable iff (rst)
        wrap_q |-> ($past(tick_i) && cnt_q == '0));

    // R4: no tick, no movement
    a_r4_cnt_frozen: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> ($stable(cnt_q) && !wrap_q));

endmodule

// File: rtl/pmg_channel.sv
module pmg_channel #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] rise_i,
    input  logic [CNT_W-1:0] fall_i,
    output logic             pin_o
);
    import pmg_pkg::*;

    pair_hit_t hit;
    pin_act_e  act;
    logic      pin_q;

    always_comb begin
        hit.rise_hit = tick_i && (cnt_i == rise_i);
        hit.fall_hit = tick_i && (cnt_i == fall_i);
        act          = pick_act(hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q <= 1'b0;
        end else begin
            case (act)
                PA_SET:  pin_q <= 1'b1;
                PA_CLR:  pin_q <= 1'b0;
                default: pin_q <= pin_q;
            endcase
        end
    end

    assign pin_o = pin_q;

    // R5: a lone rising hit raises the pin
    a_r5_rise_sets: assert property (@(posedge clk) disable iff (rst)
        (tick_i && cnt_i == rise_i && cnt_i != fall_i) |=> pin_q);

    // R6 / R7: a falling hit lowers the pin, even alongside a rising hit
    a_r7_fall_wins: assert property (@(posedge clk) disable iff (rst)
        (tick_i && cnt_i == fall_i) |=> !pin_q);

    // R4: pin holds while the tick is low
    a_r4_pin_frozen: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(pin_q));

endmodule

// File: rtl/pwm_match_gen.sv
module pwm_match_gen #(
    parameter int unsigned      CNT_W     = 16,
    parameter int unsigned      NUM_OUT   = 4,
    parameter logic [CNT_W-1:0] LIMIT_RST = '1,
    localparam int unsigned     ADDR_W    = pmg_pkg::addr_bits(NUM_OUT)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [CNT_W-1:0]   wr_data_i,
    output logic [NUM_OUT-1:0] pwm_o,
    output logic               wrap_o
);
    logic [CNT_W-1:0]             lim;
    logic [CNT_W-1:0]             cnt;
    logic                         load;
    logic [NUM_OUT-1:0][CNT_W-1:0] rise_v;
    logic [NUM_OUT-1:0][CNT_W-1:0] fall_v;

    pmg_regbank #(
        .CNT_W     (CNT_W),
        .NUM_OUT   (NUM_OUT),
        .LIMIT_RST (LIMIT_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .load_i    (load),
        .lim_o     (lim),
        .rise_o    (rise_v),
        .fall_o    (fall_v)
    );

    pmg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .lim_i  (lim),
        .cnt_o  (cnt),
        .load_o (load),
        .wrap_o (wrap_o)
    );

    for (genvar n = 0; n < NUM_OUT; n++) begin : g_ch
        pmg_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .tick_i (tick_i),
            .cnt_i  (cnt),
            .rise_i (rise_v[n]),
            .fall_i (fall_v[n]),
            .pin_o  (pwm_o[n])
        );
    end

    // R1: quiet outputs in the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (pwm_o == '0 && !wrap_o));

endmodule

// File: tb/sim_pwm_match_gen.sv
module sim_pwm_match_gen;
    localparam int CW = 16;
    localparam int NO = 4;
    localparam int AW = $clog2(2 * NO + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          tick;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [CW-1:0] wr_data;
    logic [NO-1:0] pwm;
    logic          wrap;

    int nchk = 0;
    int nfail = 0;
    int cfg_l = 7;
    int cfg_s [NO];
    int cfg_c [NO];

    always #4 clk = ~clk;

    pwm_match_gen #(.CNT_W(CW), .NUM_OUT(NO), .LIMIT_RST(16'd7)) u0 (
        .clk(clk), .rst(rst), .tick_i(tick), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .pwm_o(pwm), .wrap_o(wrap)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output level in the j-th cycle of a steady period (j=0 is the wrap cycle).
    function automatic logic exp_pin(input int s, input int c, input int l, input int j);
        logic st = 1'b0;
        for (int p = 0; p < 2; p++)
            for (int k = 0; k <= l; k++) begin
                if (k == c) st = 1'b0; else if (k == s) st = 1'b1;
            end
        for (int k = 0; k < j; k++) begin
            if (k == c) st = 1'b0; else if (k == s) st = 1'b1;
        end
        return st;
    endfunction

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_wrap();
        int g = 0;
        do begin @(negedge clk); g++; end while (!wrap && g < 1000);
    endtask

    task automatic program_cfg(input int l, input int s0, input int c0, input int s1, input int c1,
                               input int s2, input int c2, input int s3, input int c3);
        wr(0, s0); wr(1, c0); wr(2, s1); wr(3, c1);
        wr(4, s2); wr(5, c2); wr(6, s3); wr(7, c3);
        wr(2 * NO, l);
        cfg_l = l;
        cfg_s[0] = s0; cfg_c[0] = c0; cfg_s[1] = s1; cfg_c[1] = c1;
        cfg_s[2] = s2; cfg_c[2] = c2; cfg_s[3] = s3; cfg_c[3] = c3;
    endtask

    // Skips one period so state from an older setting is gone, then checks one.
    task automatic check_period(input string req);
        int bad [NO];
        int wbad = 0;
        for (int n = 0; n < NO; n++) bad[n] = 0;
        wait_wrap();
        wait_wrap();
        for (int j = 0; j <= cfg_l + 1; j++) begin
            if (j > 0)
                for (int n = 0; n < NO; n++)
                    if (pwm[n] !== exp_pin(cfg_s[n], cfg_c[n], cfg_l, j)) bad[n]++;
            if (wrap !== (j == 0 || j == cfg_l + 1)) wbad++;
            if (j <= cfg_l) @(negedge clk);
        end
        for (int n = 0; n < NO; n++)
            check(bad[n] == 0, $sformatf("%s out%0d mismatched cycles", req, n), bad[n], 0);
        check(wbad == 0, "R2 R3 wrap placement errors", wbad, 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        check(pwm == '0 && !wrap, "R1 during reset", int'({wrap, pwm}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(pwm == '0 && !wrap, "R1 after release", int'({wrap, pwm}), 0);
    endtask

    task automatic t_default();
        for (int n = 0; n < NO; n++) begin cfg_s[n] = 0; cfg_c[n] = 0; end
        cfg_l = 7;
        tick = 1'b1;
        check_period("R7 equal compares keep low");
    endtask

    task automatic t_shadow();
        int cyc = 0;
        int hi = 0;
        wait_wrap();
        tick = 1'b0;
        program_cfg(9, 0, 3, 0, 6, 2, 5, 6, 1);
        for (int a = 2 * NO + 1; a < (1 << AW); a++) wr(a, 0);
        check(pwm == '0 && !wrap, "R4 frozen during writes", int'({wrap, pwm}), 0);
        tick = 1'b1;
        do begin
            @(negedge clk); cyc++;
            if (pwm != '0) hi++;
        end while (!wrap && cyc < 100);
        check(cyc == 8, "R8 old limit finishes period", cyc, 8);
        check(hi == 0, "R8 old compares finish period", hi, 0);
        check_period("R5 R6 R9 R11");
    endtask

    task automatic t_freeze();
        logic [NO-1:0] snap;
        int moved = 0;
        int cyc = 0;
        wait_wrap();
        repeat (2) @(negedge clk);
        snap = pwm;
        check(snap == 4'b0011, "R5 levels at count 2", int'(snap), 3);
        tick = 1'b0;
        repeat (6) begin
            @(negedge clk);
            if (pwm != snap || wrap) moved++;
        end
        check(moved == 0, "R4 outputs held with tick low", moved, 0);
        tick = 1'b1;
        do begin @(negedge clk); cyc++; end while (!wrap && cyc < 100);
        check(cyc == 8, "R4 count resumes in place", cyc, 8);
    endtask

    task automatic t_quad();
        int lag_bad = 0;
        tick = 1'b0;
        program_cfg(7, 0, 4, 2, 6, 4, 0, 6, 2);
        tick = 1'b1;
        check_period("R10 quadrature set");
        wait_wrap();
        for (int j = 0; j < 16; j++) begin
            logic a0 = exp_pin(0, 4, 7, ((j - 2) % 8 + 8) % 8);
            if (pwm[1] !== a0) lag_bad++;
            @(negedge clk);
        end
        check(lag_bad == 0, "R10 out1 lags out0 by quarter period", lag_bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset();
        t_default();
        t_shadow();
        t_freeze();
        t_quad();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule